// File: doc/BRIEF.md
# Signed-Count Barrel Shifter

This block moves a 32-bit data word by an amount and in a direction given by one signed count. A positive count moves the bits toward the least significant end (right). A negative count moves them toward the most significant end (left). A 2-bit kind selector picks how vacated positions are filled. Logical shifts insert zeros. Arithmetic right shifts insert copies of the sign bit. Rotates feed the bits that leave one end back in at the other.

The datapath is purely combinational. The shift is built as a chain of five conditional-move stages, with distances 1, 2, 4, 8 and 16, one per bit of the count magnitude. A left request is turned into a right operation: the word is bit-reversed before the stages and bit-reversed again after them. The most negative count, -32, has a magnitude that the five stages cannot express. A dedicated override gives it a defined result.

Top module: `bshift_top`

## Requirements
- R1: With kind 0 (logical) and a count from 1 to 31, the output equals the input moved right by the count, with zeros entering at the top.
- R2: With kind 0 and a count from -1 to -31 (6-bit two's complement), the output equals the input moved left by the count's magnitude, with zeros entering at the bottom.
- R3: With kind 1 (arithmetic) and a count from 1 to 31, the output is the input moved right, with every vacated top bit equal to input bit 31.
- R4: With kind 1 and a negative count, the output is identical to the kind 0 result for the same data and count, so zeros enter at the bottom.
- R5: With kind 2 (rotate), a positive count rotates right and a negative count rotates left by its magnitude. No bit is lost, so the output has as many ones as the input.
- R6: A count of 0 returns the input unchanged for every kind.
- R7: Kind 3 is reserved and returns the input unchanged for every count.
- R8: A count of -32 (binary 100000) gives all zeros for kinds 0 and 1, and returns the input unchanged for kind 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_in | input | 32 | Word to be shifted |
| shift_kind | input | 2 | 0 logical, 1 arithmetic, 2 rotate, 3 reserved (pass-through) |
| shift_cnt | input | 6 | Two's-complement count; sign selects direction (positive = right) |
| data_out | output | 32 | Shifted result |

## Verification
Each kind is swept through every count from -32 to +31 with several data patterns. A single set bit at the bottom or top shows exactly where the bit lands and what fills in behind it. A word with the sign bit set separates arithmetic fill from logical fill. An alternating 0101 pattern and an irregular mixed word expose crossed or misrouted stage wiring that a single bit could miss. Rotate runs with dense and sparse words show that bits wrap rather than vanish. The extreme counts, 0, +31, -31 and -32, are checked explicitly for every kind.

// File: rtl/bshift_pkg.sv
package bshift_pkg;

  typedef enum logic [1:0] {
    SK_LOGICAL  = 2'd0,
    SK_ARITH    = 2'd1,
    SK_ROTATE   = 2'd2,
    SK_RESERVED = 2'd3
  } shift_kind_e;

  localparam int unsigned DEF_DATA_W = 32;

endpackage

// File: rtl/bshift_decode.sv
module bshift_decode #(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned STG_N = $clog2(DATA_W),
  localparam int unsigned CNT_W = STG_N + 1
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic [1:0]       kind,
  input  logic             sign_bit,
  output logic             go_left,
  output logic [STG_N-1:0] stage_sel,
  output logic             full_span,
  output logic             fill_bit,
  output logic             is_rot,
  output logic             bypass
);
  import bshift_pkg::*;

  logic [CNT_W-1:0] mag;
  shift_kind_e      k;

  always_comb begin
    k         = shift_kind_e'(kind);
    go_left   = cnt[CNT_W-1];
    mag       = go_left ? (~cnt + 1'b1) : cnt;
    stage_sel = mag[STG_N-1:0];
    full_span = mag[CNT_W-1];
    is_rot    = (k == SK_ROTATE);
    bypass    = (k == SK_RESERVED);
    fill_bit  = (k == SK_ARITH) && !go_left && sign_bit;
  end

  always_comb begin
    AST_MAG_BOUND: assert (mag <= CNT_W'(DATA_W)); // R8
    if (cnt == '0)
      AST_ZERO_NO_STAGE: assert (stage_sel == '0 && !full_span); // R6
  end

endmodule

// File: rtl/bshift_reverse.sv
module bshift_reverse #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              en,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  logic [DATA_W-1:0] flipped;

  for (genvar i = 0; i < DATA_W; i++) begin : g_flip
    assign flipped[i] = din[DATA_W-1-i];
  end

  assign dout = en ? flipped : din;

endmodule

// File: rtl/bshift_stage.sv
module bshift_stage #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DIST   = 1
) (
  input  logic              sel,
  input  logic              rot,
  input  logic              fill,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  logic [DATA_W-1:0] moved;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    if (i + DIST < DATA_W) begin : g_in_range
      assign moved[i] = din[i+DIST];
    end else begin : g_wrap
      assign moved[i] = rot ? din[i+DIST-DATA_W] : fill;
    end
  end

  assign dout = sel ? moved : din;

  always_comb begin
    if (rot)
      AST_STAGE_KEEPS_ONES: assert ($countones(dout) == $countones(din)); // R5
    if (!sel)
      AST_STAGE_IDLE_PASS: assert (dout == din); // R6
  end

endmodule

// File: rtl/bshift_top.sv
module bshift_top #(
  parameter int unsigned DATA_W = bshift_pkg::DEF_DATA_W,
  localparam int unsigned STG_N = $clog2(DATA_W),
  localparam int unsigned CNT_W = STG_N + 1
) (
  input  logic [DATA_W-1:0] data_in,
  input  logic [1:0]        shift_kind,
  input  logic [CNT_W-1:0]  shift_cnt,
  output logic [DATA_W-1:0] data_out
);
  import bshift_pkg::*;

  logic             go_left;
  logic [STG_N-1:0] stage_sel;
  logic             full_span;
  logic             fill_bit;
  logic             is_rot;
  logic             bypass;

  logic [DATA_W-1:0]          pre;
  logic [STG_N:0][DATA_W-1:0] chain;
  logic [DATA_W-1:0]          post;
  logic [DATA_W-1:0]          net_out;

  bshift_decode #(.DATA_W(DATA_W)) u_decode (
    .cnt       (shift_cnt),
    .kind      (shift_kind),
    .sign_bit  (data_in[DATA_W-1]),
    .go_left   (go_left),
    .stage_sel (stage_sel),
    .full_span (full_span),
    .fill_bit  (fill_bit),
    .is_rot    (is_rot),
    .bypass    (bypass)
  );

  bshift_reverse #(.DATA_W(DATA_W)) u_rev_in (
    .en   (go_left),
    .din  (data_in),
    .dout (pre)
  );

  assign chain[0] = pre;

  for (genvar s = 0; s < STG_N; s++) begin : g_stage
    bshift_stage #(.DATA_W(DATA_W), .DIST(1 << s)) u_stage (
      .sel  (stage_sel[s]),
      .rot  (is_rot),
      .fill (fill_bit),
      .din  (chain[s]),
      .dout (chain[s+1])
    );
  end

  bshift_reverse #(.DATA_W(DATA_W)) u_rev_out (
    .en   (go_left),
    .din  (chain[STG_N]),
    .dout (post)
  );

  always_comb begin
    if (bypass)
      net_out = data_in;
    else if (full_span && !is_rot)
      net_out = {DATA_W{fill_bit}};
    else
      net_out = post;
  end

  assign data_out = net_out;

  always_comb begin
    if (shift_cnt == '0)
      AST_ZERO_COUNT_PASS: assert (data_out == data_in); // R6
    if (shift_kind == 2'd3)
      AST_RESERVED_PASS: assert (data_out == data_in); // R7
    if (shift_kind == 2'd2)
      AST_ROTATE_NO_LOSS: assert ($countones(data_out) == $countones(data_in)); // R5
    if (shift_kind == 2'd0 && shift_cnt == {1'b1, {STG_N{1'b0}}})
      AST_FULL_LEFT_CLEAR: assert (data_out == '0); // R8
    if (shift_kind == 2'd0 && !shift_cnt[CNT_W-1] && shift_cnt != '0)
      AST_RIGHT_TOP_ZERO: assert (data_out[DATA_W-1] == 1'b0); // R1
    if (shift_kind[1] == 1'b0 && shift_cnt[CNT_W-1])
      AST_LEFT_BOTTOM_ZERO: assert (data_out[0] == 1'b0); // R2 R4
    if (shift_kind == 2'd1 && !shift_cnt[CNT_W-1])
      AST_ARITH_SIGN_KEPT: assert (data_out[DATA_W-1] == data_in[DATA_W-1]); // R3
  end

endmodule

// File: tb/test_bshift_top.sv
module test_bshift_top;

  localparam int W = 32;
  localparam int CW = 6;

  logic          clk = 1'b0;
  logic [W-1:0]  data_in = '0;
  logic [1:0]    shift_kind = '0;
  logic [CW-1:0] shift_cnt = '0;
  logic [W-1:0]  data_out;

  int n_checks = 0;
  int n_fails  = 0;
  int cycles   = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  bshift_top #(.DATA_W(W)) i_bshift_top (
    .data_in    (data_in),
    .shift_kind (shift_kind),
    .shift_cnt  (shift_cnt),
    .data_out   (data_out)
  );

  function automatic logic [W-1:0] expect_val(logic [W-1:0] d, logic [1:0] k, int c);
    int m;
    if (k == 2'd3 || c == 0) return d;
    if (c > 0) begin
      case (k)
        2'd0: return d >> c;
        2'd1: return W'($signed(d) >>> c);
        default: return (d >> c) | (d << (W - c));
      endcase
    end
    m = -c;
    if (k == 2'd2) return (m >= W) ? d : ((d << m) | (d >> (W - m)));
    return (m >= W) ? '0 : (d << m);
  endfunction

  task automatic apply(logic [W-1:0] d, logic [1:0] k, int c, string req);
    logic [W-1:0] exp_v;
    @(posedge clk);
    data_in    = d;
    shift_kind = k;
    shift_cnt  = CW'(c);
    exp_v      = expect_val(d, k, c);
    @(negedge clk);
    n_checks++;
    if (data_out !== exp_v) begin
      n_fails++;
      $display("FAIL %s kind=%0d cnt=%0d data=%h actual=%h expected=%h",
               req, k, c, d, data_out, exp_v);
    end
  endtask

  task automatic t_idle_inputs();
    apply('0, 2'd0, 0, "R6");
  endtask

  task automatic t_logical_right();
    logic [W-1:0] pats [4] = '{32'h8000_0000, 32'h0000_0001, 32'hA5C3_0F96, 32'hFFFF_FFFF};
    foreach (pats[p]) for (int c = 1; c <= 31; c++) apply(pats[p], 2'd0, c, "R1");
  endtask

  task automatic t_logical_left();
    logic [W-1:0] pats [4] = '{32'h0000_0001, 32'h8000_0000, 32'h5555_5555, 32'hDEAD_BEEF};
    foreach (pats[p]) for (int c = -31; c <= -1; c++) apply(pats[p], 2'd0, c, "R2");
  endtask

  task automatic t_arith_right();
    logic [W-1:0] pats [4] = '{32'h8000_0000, 32'h7FFF_FFFF, 32'hC001_F00D, 32'h1234_5678};
    foreach (pats[p]) for (int c = 1; c <= 31; c++) apply(pats[p], 2'd1, c, "R3");
  endtask

  task automatic t_arith_left();
    logic [W-1:0] pats [3] = '{32'hFFFF_FFFF, 32'h8000_0001, 32'h6B2E_91D4};
    foreach (pats[p]) for (int c = -31; c <= -1; c++) apply(pats[p], 2'd1, c, "R4");
  endtask

  task automatic t_rotate();
    logic [W-1:0] pats [4] = '{32'h0000_0001, 32'h8000_0000, 32'hF0E1_D2C3, 32'hAAAA_5555};
    foreach (pats[p]) for (int c = -31; c <= 31; c++) apply(pats[p], 2'd2, c, "R5");
  endtask

  task automatic t_zero_count();
    for (int k = 0; k < 4; k++) begin
      apply(32'h9BAD_F00D, 2'(k), 0, "R6");
      apply(32'h0000_8001, 2'(k), 0, "R6");
    end
  endtask

  task automatic t_reserved();
    for (int c = -32; c <= 31; c++) apply(32'hC3A5_5A3C, 2'd3, c, "R7");
  endtask

  task automatic t_full_left();
    logic [W-1:0] pats [3] = '{32'hFFFF_FFFF, 32'h8000_0000, 32'h1357_9BDF};
    foreach (pats[p]) begin
      apply(pats[p], 2'd0, -32, "R8");
      apply(pats[p], 2'd1, -32, "R8");
      apply(pats[p], 2'd2, -32, "R8");
    end
  endtask

  initial begin : watchdog
    while (!finished) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000 && !finished) begin
        n_fails++;
        n_checks++;
        $display("FAIL watchdog actual=%0d cycles expected<=100000", cycles);
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
      end
    end
  end

  initial begin : main
    t_idle_inputs();
    t_logical_right();
    t_logical_left();
    t_arith_right();
    t_arith_left();
    t_rotate();
    t_zero_count();
    t_reserved();
    t_full_left();
    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule